// File: doc/BRIEF.md
# Power-of-Two Watchdog Timer

This block is a register-mapped watchdog. Once software enables it, a counter advances on every cycle of the block's single clock. If the count reaches a limit of 2^(delay+1) cycles, the block issues a one-cycle system reset request. Software keeps the timer alive by writing two fixed 32-bit key words, in order, to two key registers. Any other key write while the timer runs is treated as a fault and also triggers a reset. Software can also request a reset directly through a dedicated register.

Each reset event records its cause in a small field. The field survives every internal reset and is cleared only by the hard reset input. Software reads it back after boot to learn why the system restarted. A request to stop the timer does not take effect at once: the counter keeps running until a valid key sequence is written after the stop. A lone write therefore cannot silence a runaway system.

Top module: `pow2_wdt`

## Requirements
- R1: After the hard reset input (rst_n low, then released), sys_rst_req_o is 0, the configuration register reads 0 and the cause field reads 0 (hard reset).
- R2: Byte offset 0x04 is the configuration register. Bit 31 is the enable bit and bits [4:0] are the delay. Both read back as written. Reading offset 0x08 returns the cause in bits [2:0], with zeros above.
- R3: Writing the configuration register with bit 31 set, while the timer is stopped, starts the count at that write's clock edge. sys_rst_req_o then goes high for exactly one cycle, 2^(delay+1) edges after the start edge, and the cause becomes 1 (timeout).
- R4: Writing 0xABCD1234 to offset 0x08 and then 0x4321DCBA to offset 0x0C restarts the count from the second write's edge. If that second write lands on the edge where the timeout would fire, the restart wins and no request is issued.
- R5: While the timer runs, two cases trigger a one-cycle request and set the cause to 2. The first is any other value written to 0x08. The second is a write to 0x0C that is not the correct word or is not preceded by a correct word at 0x08. While the timer is stopped, such writes have no effect on the output or the cause.
- R6: Writing a value with bit 0 set to offset 0x00 issues a one-cycle request on the following cycle and sets the cause to 3. If bit 0 is clear, the write has no effect.
- R7: Asserting user_rst_i sets the cause to 4, stops the timer and issues no request.
- R8: Clearing the enable bit while the timer runs does not stop the count. The timer stops only when a valid key sequence completes afterwards. Until then a timeout still fires on schedule.
- R9: Writing a different delay while the timer runs clears the count at that write, so the new period is measured from the write.
- R10: Every reset event (timeout, key fault, software request, user reset) clears the configuration register and stops the timer, and the cause field is kept.
- R11: When several events coincide, the cause is chosen in this order: user reset first, then software request, then key fault, then timeout. A user reset suppresses the request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and register clock |
| rst_n | input | 1 | Hard reset, asynchronous assert, active low |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| user_rst_i | input | 1 | External user reset indication |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The checker assumes the surrounding system reacts to a reset request before software acts again. No bus write and no user reset arrives in the cycle right after sys_rst_req_o is high, which is what lets the request be checked as a single-cycle pulse. The bench honours this by always letting at least one idle cycle pass after every observed request before it issues the next access. Key sequences in the random phase are placed so that both writes finish no later than one cycle before the deadline. The exact-deadline case is driven only as a directed test.

// File: rtl/pow2_wdt_pkg.sv
package pow2_wdt_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned EN_BIT = 31;

  // word index of each register (byte offset >> 2)
  localparam logic [1:0] IDX_SOFT = 2'd0;
  localparam logic [1:0] IDX_CFG  = 2'd1;
  localparam logic [1:0] IDX_KEY1 = 2'd2;
  localparam logic [1:0] IDX_KEY2 = 2'd3;

  localparam logic [DATA_W-1:0] KEY1_WORD = 32'hABCD_1234;
  localparam logic [DATA_W-1:0] KEY2_WORD = 32'h4321_DCBA;

  typedef enum logic [2:0] {
    CAUSE_HARD   = 3'd0,
    CAUSE_EXPIRE = 3'd1,
    CAUSE_BADKEY = 3'd2,
    CAUSE_SOFT   = 3'd3,
    CAUSE_USER   = 3'd4
  } cause_e;

endpackage

// File: rtl/pow2_wdt_rst_sync.sv
module pow2_wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pow2_wdt_regs.sv
module pow2_wdt_regs
  import pow2_wdt_pkg::*;
#(
  parameter int unsigned DELAY_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                warm_clr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic                cfg_en,
  output logic [DELAY_W-1:0]  cfg_delay,
  output logic                run,
  output logic                cnt_clr,
  output logic                kick,
  output logic                bad_key,
  output logic                soft_req
);
  logic               en_q, en_d;
  logic [DELAY_W-1:0] delay_q, delay_d;
  logic               run_q, run_d;
  logic               armed_q, armed_d;
  logic               state_ce;

  logic               aligned;
  logic               wr_soft, wr_cfg, wr_k1, wr_k2;
  logic               k1_match, k2_good;
  logic               new_en;
  logic [DELAY_W-1:0] new_delay;
  logic               start, reload;

  always_comb begin
    aligned   = (bus_addr[1:0] == 2'b00);
    wr_soft   = bus_we && aligned && (bus_addr[3:2] == IDX_SOFT);
    wr_cfg    = bus_we && aligned && (bus_addr[3:2] == IDX_CFG);
    wr_k1     = bus_we && aligned && (bus_addr[3:2] == IDX_KEY1);
    wr_k2     = bus_we && aligned && (bus_addr[3:2] == IDX_KEY2);
    k1_match  = (bus_wdata == KEY1_WORD);
    k2_good   = wr_k2 && armed_q && (bus_wdata == KEY2_WORD);
    new_en    = bus_wdata[EN_BIT];
    new_delay = bus_wdata[DELAY_W-1:0];

    kick      = k2_good;
    bad_key   = run_q && ((wr_k1 && !k1_match) || (wr_k2 && !k2_good));
    soft_req  = wr_soft && bus_wdata[0];
    start     = wr_cfg && new_en && !run_q;
    reload    = wr_cfg && run_q && (new_delay != delay_q);
    cnt_clr   = start || reload || kick;
  end

  always_comb begin
    en_d    = en_q;
    delay_d = delay_q;
    run_d   = run_q;
    armed_d = armed_q;
    if (wr_cfg) begin
      en_d    = new_en;
      delay_d = new_delay;
      if (new_en) run_d = 1'b1;
    end
    if (wr_k1) armed_d = k1_match;
    if (wr_k2) begin
      armed_d = 1'b0;
      // a pending stop completes only on a valid sequence
      if (k2_good && !en_q) run_d = 1'b0;
    end
    if (warm_clr) begin
      en_d    = 1'b0;
      delay_d = '0;
      run_d   = 1'b0;
      armed_d = 1'b0;
    end
  end

  assign state_ce = warm_clr || wr_cfg || wr_k1 || wr_k2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      delay_q <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (state_ce) begin
      en_q    <= en_d;
      delay_q <= delay_d;
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end

  assign cfg_en    = en_q;
  assign cfg_delay = delay_q;
  assign run       = run_q;
endmodule

// File: rtl/pow2_wdt_counter.sv
module pow2_wdt_counter #(
  parameter int unsigned DELAY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clr,
  input  logic               warm_clr,
  input  logic [DELAY_W-1:0] delay,
  output logic               expire,
  output logic [(1<<DELAY_W)-1:0] cnt
);
  localparam int unsigned CNT_W = 1 << DELAY_W;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cnt_ce;

  // last count value is 2^(delay+1)-1; CNT_W-1 is all ones in DELAY_W bits,
  // so the shift amount CNT_W-1-delay equals ~delay
  assign limit = ALL_ONES >> (~delay);

  always_comb begin
    expire = run && !clr && (cnt_q == limit);
    if (warm_clr || clr || !run) cnt_d = '0;
    else                         cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    cnt_ce = run || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pow2_wdt_cause.sv
module pow2_wdt_cause
  import pow2_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       user_rst,
  input  logic       soft_req,
  input  logic       bad_key,
  input  logic       expire,
  output logic [2:0] cause,
  output logic       warm_clr,
  output logic       req
);
  cause_e cause_q, cause_d;
  logic   req_q, req_d;

  always_comb begin
    warm_clr = user_rst || soft_req || bad_key || expire;
    req_d    = !user_rst && (soft_req || bad_key || expire);
    cause_d  = cause_q;
    if (user_rst)      cause_d = CAUSE_USER;
    else if (soft_req) cause_d = CAUSE_SOFT;
    else if (bad_key)  cause_d = CAUSE_BADKEY;
    else if (expire)   cause_d = CAUSE_EXPIRE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_HARD;
      req_q   <= 1'b0;
    end else begin
      req_q <= req_d;
      if (warm_clr) cause_q <= cause_d;
    end
  end

  assign cause = cause_q;
  assign req   = req_q;
endmodule

// File: rtl/pow2_wdt.sv
module pow2_wdt
  import pow2_wdt_pkg::*;
#(
  parameter int unsigned DELAY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              user_rst_i,
  output logic              sys_rst_req_o
);
  localparam int unsigned CNT_W = 1 << DELAY_W;

  logic               rst_n_s;
  logic               cfg_en, run, cnt_clr, kick, bad_key, soft_req;
  logic [DELAY_W-1:0] cfg_delay;
  logic               warm_clr, expire;
  logic [CNT_W-1:0]   cnt;
  logic [2:0]         cause;

  pow2_wdt_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pow2_wdt_regs #(.DELAY_W(DELAY_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .warm_clr(warm_clr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .cfg_en(cfg_en), .cfg_delay(cfg_delay), .run(run), .cnt_clr(cnt_clr),
    .kick(kick), .bad_key(bad_key), .soft_req(soft_req)
  );

  pow2_wdt_counter #(.DELAY_W(DELAY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .run(run), .clr(cnt_clr),
    .warm_clr(warm_clr), .delay(cfg_delay), .expire(expire), .cnt(cnt)
  );

  pow2_wdt_cause u_cause (
    .clk(clk), .rst_n(rst_n_s), .user_rst(user_rst_i), .soft_req(soft_req),
    .bad_key(bad_key), .expire(expire), .cause(cause),
    .warm_clr(warm_clr), .req(sys_rst_req_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr[3:2])
        IDX_CFG: begin
          bus_rdata[EN_BIT]        = cfg_en;
          bus_rdata[DELAY_W-1:0]   = cfg_delay;
        end
        IDX_KEY1: bus_rdata[2:0] = cause;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pow2_wdt_chk.sv
module pow2_wdt_chk #(
  parameter int unsigned DELAY_W = 5
) (
  input logic                    clk,
  input logic                    rst_n_s,
  input logic                    run,
  input logic                    cfg_en,
  input logic                    kick,
  input logic                    warm_clr,
  input logic                    expire,
  input logic [(1<<DELAY_W)-1:0] cnt,
  input logic [2:0]              cause,
  input logic                    user_rst_i,
  input logic                    sys_rst_req_o
);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sys_rst_req_o |=> !sys_rst_req_o);

  // R3
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sys_rst_req_o |-> (cause == 3'd1 || cause == 3'd2 || cause == 3'd3));

  // R1
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cause <= 3'd4);

  // R7
  user_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    user_rst_i |=> (cause == 3'd4 && !sys_rst_req_o));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run && !cfg_en && !kick && !warm_clr) |=> run);

  // R10
  warm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    warm_clr |=> (!run && cnt == '0));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run |-> !expire);
endmodule

bind pow2_wdt pow2_wdt_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .run(run), .cfg_en(cfg_en), .kick(kick),
  .warm_clr(warm_clr), .expire(expire), .cnt(cnt), .cause(cause),
  .user_rst_i(user_rst_i), .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/pow2_wdt_tb_top.sv
module pow2_wdt_tb_top;
  localparam logic [1:0] I_SOFT = 2'd0, I_CFG = 2'd1, I_K1 = 2'd2, I_K2 = 2'd3;
  localparam logic [31:0] KW1 = 32'hABCD_1234, KW2 = 32'h4321_DCBA;

  logic        clk, rst_n, bus_we, user_rst_i, sys_rst_req_o;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          checks, errors;
  bit          done;

  pow2_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .user_rst_i(user_rst_i),
    .sys_rst_req_o(sys_rst_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int period(input int d);
    return 1 << (d + 1);
  endfunction

  function automatic logic [31:0] cfg_word(input bit en, input int d);
    return {en, 26'd0, d[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one write consumes exactly one rising edge; starts and ends at a negedge
  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    bus_addr = {idx, 2'b00}; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    bus_addr = {idx, 2'b00};
    #1 d = bus_rdata;
  endtask

  task automatic kick_seq();
    wr(I_K1, KW1);
    wr(I_K2, KW2);
  endtask

  task automatic watch(input int n, input string tag);
    int hits;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_req_o) hits++;
    end
    chk(tag, hits, 0);
  endtask

  task automatic expect_timeout(input int n, input string tag);
    logic [31:0] v;
    watch(n - 1, {tag, " quiet"});
    step(1);
    chk({tag, " pulse"}, sys_rst_req_o, 1);
    step(1);
    chk({tag, " pulse end"}, sys_rst_req_o, 0);
    rd(I_K1, v);
    chk({tag, " cause"}, v, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int d, n, k, w;
    checks = 0; errors = 0; done = 0;
    rst_n = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; user_rst_i = 0;
    void'($urandom(32'h00C0_FFEE));
    step(3);
    rst_n = 1;
    step(4);

    // R1 reset state
    chk("R1 req", sys_rst_req_o, 0);
    rd(I_CFG, v); chk("R1 cfg", v, 0);
    rd(I_K1, v);  chk("R1 cause", v, 0);

    // R2 readback; R5 key faults ignored while stopped
    wr(I_CFG, cfg_word(0, 7));
    rd(I_CFG, v); chk("R2 cfg delay", v, 32'h0000_0007);
    wr(I_K2, 32'h1111_2222);
    wr(I_K1, 32'h0);
    watch(4, "R5 stopped fault");
    rd(I_K1, v); chk("R5 cause kept", v, 0);

    // R3 timeout at delay 0 and 3
    wr(I_CFG, cfg_word(1, 0));
    expect_timeout(period(0), "R3 d0");
    rd(I_CFG, v); chk("R10 cfg cleared", v, 0);
    wr(I_CFG, cfg_word(1, 3));
    rd(I_CFG, v); chk("R2 cfg en", v, 32'h8000_0003);
    expect_timeout(period(3), "R3 d3");

    // R4 keep-alive on the deadline edge wins
    wr(I_CFG, cfg_word(1, 2));
    watch(period(2) - 2, "R4 before");
    kick_seq();
    chk("R4 deadline", sys_rst_req_o, 0);
    expect_timeout(period(2), "R4 after deadline");

    // R5 wrong word 1 while running
    wr(I_CFG, cfg_word(1, 4));
    step(3);
    wr(I_K1, 32'hABCD_1235);
    chk("R5 bad k1 pulse", sys_rst_req_o, 1);
    step(1);
    rd(I_K1, v); chk("R5 bad k1 cause", v, 2);
    rd(I_CFG, v); chk("R10 cfg after fault", v, 0);

    // R5 word 2 without word 1
    wr(I_CFG, cfg_word(1, 4));
    wr(I_K2, KW2);
    chk("R5 lone k2 pulse", sys_rst_req_o, 1);
    step(1);
    rd(I_K1, v); chk("R5 lone k2 cause", v, 2);

    // R8 stop deferred: timeout still fires
    wr(I_CFG, cfg_word(1, 2));
    wr(I_CFG, cfg_word(0, 2));
    watch(period(2) - 2, "R8 pending quiet");
    step(1);
    chk("R8 pending pulse", sys_rst_req_o, 1);
    step(1);
    rd(I_K1, v); chk("R8 pending cause", v, 1);

    // R8 stop completes after a valid sequence
    wr(I_CFG, cfg_word(1, 2));
    wr(I_CFG, cfg_word(0, 2));
    kick_seq();
    watch(3 * period(2), "R8 stopped");
    rd(I_CFG, v); chk("R8 cfg", v, 32'h0000_0002);
    wr(I_K1, 32'hDEAD_BEEF);
    watch(2, "R5 fault after stop");
    rd(I_K1, v); chk("R5 cause after stop", v, 1);

    // R9 delay change reloads the count
    wr(I_CFG, cfg_word(1, 1));
    step(2);
    wr(I_CFG, cfg_word(1, 3));
    expect_timeout(period(3), "R9 reload");

    // R6 software reset
    wr(I_SOFT, 32'h0000_0000);
    watch(2, "R6 bit0 clear");
    rd(I_K1, v); chk("R6 no effect cause", v, 1);
    wr(I_CFG, cfg_word(1, 5));
    wr(I_SOFT, 32'h0000_0001);
    chk("R6 pulse", sys_rst_req_o, 1);
    step(1);
    chk("R6 pulse end", sys_rst_req_o, 0);
    rd(I_K1, v); chk("R6 cause", v, 3);
    watch(period(5) + 4, "R10 stopped after soft");

    // R11 user reset beats software request
    bus_addr = {I_SOFT, 2'b00}; bus_wdata = 32'h1; bus_we = 1; user_rst_i = 1;
    @(negedge clk);
    bus_we = 0; user_rst_i = 0;
    chk("R11 no pulse", sys_rst_req_o, 0);
    rd(I_K1, v); chk("R11 cause", v, 4);

    // R7 user reset stops a running timer
    wr(I_SOFT, 32'h1);
    step(1);
    wr(I_CFG, cfg_word(1, 2));
    step(2);
    user_rst_i = 1;
    @(negedge clk);
    user_rst_i = 0;
    chk("R7 no pulse", sys_rst_req_o, 0);
    rd(I_K1, v); chk("R7 cause", v, 4);
    watch(2 * period(2), "R7 stopped");

    // R3 R4 random keep-alive spacing, then timeout
    for (int it = 0; it < 12; it++) begin
      d = 1 + int'($urandom % 5);
      n = period(d);
      k = int'($urandom % 4);
      wr(I_CFG, cfg_word(1, d));
      for (int j = 0; j < k; j++) begin
        w = int'($urandom % (n - 2));
        watch(w, "R4 random gap");
        kick_seq();
      end
      expect_timeout(n, "R3 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule